// File: doc/BRIEF.md
# Quad-rate burst-two SRAM core

This block is a synthesizable, small-depth synchronous SRAM. It has one input data bus for writes and one output data bus for reads. Both are double data rate, and one shared address bus is also used on both clock edges. In every clock cycle the block can take one read request and one write request. Each request moves a burst of two words: the first word on the rising edge and the second on the falling edge. With two ports that gives four word transfers per clock. The array holds `2**(ADDR_W+1)` words. A burst at burst address A covers word locations 2A (first word) and 2A+1 (second word).

The rising edge carries the read address, the two active-low request strobes, the first write word and that word's lane enables. The falling edge of the same cycle carries the write address, the second write word and its lane enables. Read data comes out 1.5 cycles after the request, together with a valid flag and an echo clock for capturing it at the far end.

The streaming interface has no back-pressure. The ready side is implicitly always true, so every request strobe seen on a rising edge is accepted. The read output has no stall input: a receiver must take each word in the half-cycle in which the valid flag marks it.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0, `echo_clk` is 0 and `rdata` is all zeros.
- R2: For a read strobe (`rd_n`=0) sampled on rising edge k, the first word is driven with `rvalid`=1 from falling edge k+1 to rising edge k+2. The second word is driven with `rvalid`=1 from rising edge k+2 to falling edge k+2.
- R3: The address bus is sampled as the read burst address on the rising edge and as the write burst address on the falling edge of the same cycle. Burst address A maps the first word to location 2A and the second word to location 2A+1.
- R4: `rd_n` and `wr_n` are sampled only on rising edges. Their values at falling edges have no effect on the outputs or on the stored data.
- R5: Lane i of a word is bits [i*LANE_W +: LANE_W]. It is written only when bit i of `wben_n` is 0 at the edge that carries that word. A lane whose enable is 1 keeps its old contents.
- R6: A read and a write to the same burst address sampled on the same rising edge cause the read to return the contents from before that write. A read sampled on the next rising edge returns the new contents.
- R7: `echo_clk` is 1 while a valid first word is driven and 0 while a second word is driven. It stays at 0 whenever `rvalid` is 0.
- R8: `rdata` is all zeros whenever `rvalid` is 0.
- R9: A read and a write can be accepted in every cycle with no idle gap. Consecutive reads produce an unbroken stream of words, two per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read request strobe, rising edge only |
| wr_n | input | 1 | Active-low write request strobe, rising edge only |
| addr | input | ADDR_W | Burst address: read on rising edge, write on falling edge |
| wdata | input | WORD_W | Write word: first on rising edge, second on falling edge |
| wben_n | input | WORD_W/LANE_W | Active-low lane write enables, one per lane, qualified with each word |
| rdata | output | WORD_W | Read word, first in the low phase and second in the high phase |
| rvalid | output | 1 | High while `rdata` carries a valid word |
| echo_clk | output | 1 | Capture clock that toggles only while read data is valid |

## Verification
The hardest case to reach from the ports is the same-cycle collision. A read and a write address the same burst in one cycle, so the write's commit and the read's array fetch happen on the same edge. The bench gives each burst address a pair of calls. The first call reads and writes that address together and expects the old words. The second call reads again and expects the merged new words. A second hard case is a strobe that changes value at the falling edge. The bench drives the inverse strobe levels in every high phase, so a design that samples them on the wrong edge corrupts the arithmetic model at once. A full sweep of the sixteen lane-enable combinations at every address covers the masking.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned BURST_LEN = 2;

  function automatic int unsigned lane_count(int unsigned word_w, int unsigned lane_w);
    return word_w / lane_w;
  endfunction
endpackage

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wben_n,
  output logic              cm_v,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [WORD_W-1:0] cm_d0,
  output logic [WORD_W-1:0] cm_d1,
  output logic [LANES-1:0]  cm_en0,
  output logic [LANES-1:0]  cm_en1
);
  logic              req_r;
  logic [WORD_W-1:0] d0_r;
  logic [LANES-1:0]  en0_r;

  // rising half: strobe, first word and its lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_r <= 1'b0;
      d0_r  <= '0;
      en0_r <= '0;
    end else begin
      req_r <= ~wr_n;
      d0_r  <= wdata;
      en0_r <= ~wben_n;
    end
  end

  // falling half: address, second word and its lanes
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_v    <= 1'b0;
      cm_addr <= '0;
      cm_d0   <= '0;
      cm_d1   <= '0;
      cm_en0  <= '0;
      cm_en1  <= '0;
    end else begin
      cm_v    <= req_r;
      cm_addr <= addr;
      cm_d0   <= d0_r;
      cm_d1   <= wdata;
      cm_en0  <= en0_r;
      cm_en1  <= ~wben_n;
    end
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         cm_v,
  input  logic [ADDR_W-1:0]            cm_addr,
  input  logic [WORD_W-1:0]            cm_d0,
  input  logic [WORD_W-1:0]            cm_d1,
  input  logic [WORD_W/LANE_W-1:0]     cm_en0,
  input  logic [WORD_W/LANE_W-1:0]     cm_en1,
  output logic                         f_v,
  output logic [WORD_W-1:0]            f_d0,
  output logic [WORD_W-1:0]            f_d1
);
  localparam int unsigned LANES = lane_count(WORD_W, LANE_W);
  localparam int unsigned DEPTH = BURST_LEN << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              rq_r;
  logic [ADDR_W-1:0] ra_r;

  logic [BURST_LEN-1:0][WORD_W-1:0] new_d;
  logic [BURST_LEN-1:0][LANES-1:0]  new_en;
  logic [BURST_LEN-1:0][WORD_W-1:0] merged;

  assign new_d[0]  = cm_d0;
  assign new_d[1]  = cm_d1;
  assign new_en[0] = cm_en0;
  assign new_en[1] = cm_en1;

  // per beat, per lane merge of new data over stored data
  for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[b][l*LANE_W +: LANE_W] = new_en[b][l]
        ? new_d[b][l*LANE_W +: LANE_W]
        : mem[{cm_addr, 1'(b)}][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (cm_v) begin
      for (int b = 0; b < BURST_LEN; b++) mem[{cm_addr, 1'(b)}] <= merged[b];
    end
  end

  // request capture, then fetch one cycle later (sees writes committed before)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_r <= 1'b0;
      ra_r <= '0;
      f_v  <= 1'b0;
      f_d0 <= '0;
      f_d1 <= '0;
    end else begin
      rq_r <= ~rd_n;
      ra_r <= addr;
      f_v  <= rq_r;
      f_d0 <= mem[{ra_r, 1'b0}];
      f_d1 <= mem[{ra_r, 1'b1}];
    end
  end
endmodule

// File: rtl/qdr_rd_launch.sv
module qdr_rd_launch #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_v,
  input  logic [WORD_W-1:0] f_d0,
  input  logic [WORD_W-1:0] f_d1,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              echo_clk
);
  logic              lo_v;
  logic [WORD_W-1:0] lo_d0;
  logic [WORD_W-1:0] lo_d1;
  logic              hi_v;
  logic [WORD_W-1:0] hi_d;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_v  <= 1'b0;
      lo_d0 <= '0;
      lo_d1 <= '0;
    end else begin
      lo_v  <= f_v;
      lo_d0 <= f_v ? f_d0 : '0;
      lo_d1 <= f_v ? f_d1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_v <= 1'b0;
      hi_d <= '0;
    end else begin
      hi_v <= lo_v;
      hi_d <= lo_d1;
    end
  end

  // output select by clock level: low phase first word, high phase second
  assign rdata    = clk ? hi_d : lo_d0;
  assign rvalid   = clk ? hi_v : lo_v;
  assign echo_clk = ~clk & lo_v;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [WORD_W/LANE_W-1:0] wben_n,
  output logic [WORD_W-1:0]        rdata,
  output logic                     rvalid,
  output logic                     echo_clk
);
  localparam int unsigned LANES = qdr_pkg::lane_count(WORD_W, LANE_W);

  logic              cm_v;
  logic [ADDR_W-1:0] cm_addr;
  logic [WORD_W-1:0] cm_d0, cm_d1;
  logic [LANES-1:0]  cm_en0, cm_en1;
  logic              f_v;
  logic [WORD_W-1:0] f_d0, f_d1;

  qdr_wr_capture #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wcap (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .wben_n(wben_n), .cm_v(cm_v), .cm_addr(cm_addr), .cm_d0(cm_d0),
    .cm_d1(cm_d1), .cm_en0(cm_en0), .cm_en1(cm_en1)
  );

  qdr_array #(.WORD_W(WORD_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .addr(addr), .cm_v(cm_v),
    .cm_addr(cm_addr), .cm_d0(cm_d0), .cm_d1(cm_d1), .cm_en0(cm_en0),
    .cm_en1(cm_en1), .f_v(f_v), .f_d0(f_d0), .f_d1(f_d1)
  );

  qdr_rd_launch #(.WORD_W(WORD_W)) u_rlaunch (
    .clk(clk), .rst_n(rst_n), .f_v(f_v), .f_d0(f_d0), .f_d1(f_d1),
    .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk)
  );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid,
  input logic              echo_clk
);
  logic rq1, rq2, rq3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1 <= 1'b0;
      rq2 <= 1'b0;
      rq3 <= 1'b0;
    end else begin
      rq1 <= ~rd_n;
      rq2 <= rq1;
      rq3 <= rq2;
    end
  end

  // R2: first word valid in the low phase 1.5 cycles after the strobe
  p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == rq2);
  // R2: second word valid in the following high phase
  p_second_word_r2: assert property (@(negedge clk) disable iff (!rst_n)
    rvalid == rq3);
  // R7: echo high with each valid first word, low otherwise in the low phase
  p_echo_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    echo_clk == rvalid);
  // R7: echo low throughout the high phase
  p_echo_high_phase_r7: assert property (@(negedge clk) disable iff (!rst_n)
    !echo_clk);
  // R8: quiet bus when nothing is valid
  p_idle_zero_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
  p_idle_zero_hi_r8: assert property (@(negedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rdata(rdata), .rvalid(rvalid),
  .echo_clk(echo_clk)
);

// File: tb/sim_qdr_b2_sram.sv
module sim_qdr_b2_sram;
  localparam int CLK_P = 10;
  localparam int W  = 16;
  localparam int LW = 8;
  localparam int AW = 3;
  localparam int LN = W / LW;
  localparam int NB = 1 << AW;
  localparam int NW = 2 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [LN-1:0] wben_n = '1;
  logic [W-1:0]  rdata;
  logic          rvalid, echo_clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] model [NW];
  logic         pv [2];
  logic [W-1:0] p0 [2], p1 [2];

  always #(CLK_P/2) clk = ~clk;

  qdr_b2_sram #(.WORD_W(W), .LANE_W(LW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .wben_n(wben_n), .rdata(rdata), .rvalid(rvalid),
    .echo_clk(echo_clk)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int a, int b, int s);
    return W'(a * 16'h1357 + b * 16'h0f0f + s * 16'h2469 + 16'h00a5);
  endfunction

  // one clock cycle starting just after a falling edge
  task automatic cyc(string ph, bit rd, int ra, bit wr, int wa,
                     logic [W-1:0] d0, logic [LN-1:0] b0n,
                     logic [W-1:0] d1, logic [LN-1:0] b1n);
    logic         nv;
    logic [W-1:0] n0, n1;
    chk({ph, " R2 rvalid low phase"}, W'(rvalid), W'(pv[1]));
    if (pv[1]) chk({ph, " R3 first word"}, rdata, p0[1]);
    else       chk({ph, " R8 idle data low phase"}, rdata, '0);
    chk({ph, " R7 echo low phase"}, W'(echo_clk), W'(pv[1]));
    nv = rd;
    n0 = model[2*(ra % NB)];
    n1 = model[2*(ra % NB) + 1];
    rd_n = ~rd; wr_n = ~wr; addr = AW'(ra); wdata = d0; wben_n = b0n;
    @(posedge clk); #1;
    // R4: strobes flipped in the second half must be ignored
    rd_n = rd; wr_n = wr; addr = AW'(wa); wdata = d1; wben_n = b1n;
    chk({ph, " R2 rvalid high phase"}, W'(rvalid), W'(pv[1]));
    chk({ph, " R3 second word"}, rdata, pv[1] ? p1[1] : '0);
    chk({ph, " R7 echo high phase"}, W'(echo_clk), '0);
    pv[1] = pv[0]; p0[1] = p0[0]; p1[1] = p1[0];
    pv[0] = nv;    p0[0] = n0;    p1[0] = n1;
    if (wr) begin
      for (int l = 0; l < LN; l++) begin
        if (!b0n[l]) model[2*(wa % NB)][l*LW +: LW] = d0[l*LW +: LW];
        if (!b1n[l]) model[2*(wa % NB) + 1][l*LW +: LW] = d1[l*LW +: LW];
      end
    end
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    int prev;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; p0[i] = '0; p1[i] = '0; end
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset rvalid", W'(rvalid), '0);
    chk("R1 reset echo", W'(echo_clk), '0);
    chk("R1 reset rdata", rdata, '0);
    @(posedge clk); #1;
    chk("R1 reset rvalid high", W'(rvalid), '0);
    chk("R1 reset rdata high", rdata, '0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // fill every burst with full lanes
    for (int a = 0; a < NB; a++)
      cyc("R3 fill", 0, 0, 1, a, pat(a, 0, 1), '0, pat(a, 1, 1), '0);
    // back-to-back read stream
    for (int a = 0; a < NB; a++)
      cyc("R9 stream", 1, a, 0, 0, '0, '1, '0, '1);
    // exhaustive lane-enable sweep, reading the previous burst meanwhile
    prev = 0;
    for (int a = 0; a < NB; a++) begin
      for (int m = 0; m < 16; m++) begin
        cyc("R5 lanes", 1, prev, 1, a, pat(a, 0, m + 2), LN'(m), pat(a, 1, m + 2), LN'(m >> 2));
        prev = a;
      end
    end
    // same-address collision then follow-up read
    for (int a = 0; a < NB; a++) begin
      cyc("R6 same cycle", 1, a, 1, a, pat(a, 0, 40), '0, pat(a, 1, 40), '0);
      cyc("R6 next cycle", 1, a, 0, 0, '0, '1, '0, '1);
    end
    // strobes high on rising edge, low on falling edge: nothing happens
    for (int a = 0; a < NB; a++)
      cyc("R4 ignore", 0, a, 0, a, pat(a, 0, 50), '0, pat(a, 1, 50), '0);
    for (int a = 0; a < NB; a++)
      cyc("R4 readback", 1, a, 0, 0, '0, '1, '0, '1);
    // mixed concurrent traffic
    lfsr = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R9 mixed", lfsr[0], int'(lfsr[3:1]), lfsr[4], int'(lfsr[7:5]),
          pat(int'(lfsr[7:5]), 0, i + 60), LN'(lfsr[9:8]),
          pat(int'(lfsr[7:5]), 1, i + 60), LN'(lfsr[11:10]));
    end
    cyc("R8 drain", 0, 0, 0, 0, '0, '1, '0, '1);
    cyc("R8 drain", 0, 0, 0, 0, '0, '1, '0, '1);
    cyc("R8 drain", 0, 0, 0, 0, '0, '1, '0, '1);
    finish_run();
  end
endmodule